// File: doc/BRIEF.md
# Backplane Frame Serializer

This block takes a word of independent logic signals and sends it over one backplane wire as a stream of fixed-length frames. It needs no handshake. A receiver that runs from the same nominal clock rate can rebuild the word. Each frame sends the word once, so the parallel inputs are effectively sampled at a fixed rate. That rate is set only by the channel count and the system clock.

Every serial bit lasts a fixed number of system clock cycles, eight by default. A frame has the following parts:

- a low start bit;
- the data bits, least significant first;
- an even parity bit;
- a high stop bit;
- enough high idle bits to make the frame exactly twice (N+3) bits long.

Frames follow each other with no gap. The word is captured on the clock edge that ends the first cycle of each frame, and it is held for the rest of the frame. A one-cycle pulse marks the start of every frame. While master reset is high, the line rests high. When reset is released, the first start bit appears in that same cycle.

With 32 channels and a 10 MHz clock, the line runs at 1.25 Mbit/s and the word is refreshed at about 17.8 kHz.

Top module: `bkp_frame_tx`

## Requirements
- R1: While `rst` is high, `ser_out` is 1 and `frame_start` is 0.
- R2: In the first clock cycle with `rst` low, `ser_out` is 0 and `frame_start` is 1.
- R3: Every serial bit holds `ser_out` constant for exactly CLKS_PER_BIT consecutive clock cycles (8 by default).
- R4: Bit position 0 of a frame is 0 (start). Bit position i+1 carries captured channel i, for i from 0 to N-1, so the least significant channel goes first.
- R5: Bit position N+1 carries even parity: the XOR of the N captured channel values.
- R6: Bit position N+2 (stop) and the idle positions N+3 to 2N+5 are all 1.
- R7: A frame lasts 2·(N+3) bits, which is 2·(N+3)·CLKS_PER_BIT cycles. Frames repeat back to back. `frame_start` is a one-cycle pulse in the first cycle of each start bit and is 0 at all other times.
- R8: `par_in` is captured on the clock edge that ends the first cycle of a frame. Any later change to `par_in` has no effect on that frame's data or parity bits.
- R9: Raising `rst` in the middle of a frame abandons that frame. After release, a new frame begins as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| par_in | input | CHANNELS | Parallel channel word to transmit |
| ser_out | output | 1 | Serial backplane line, high when idle |
| frame_start | output | 1 | One-cycle pulse in the first cycle of every start bit |

## Verification
The capture of a new word happens in the same cycle as the start-bit pulse. The bench therefore presents each new word during the start cycle of its frame and replaces it with its complement one cycle later. Each frame's data and parity bits must then reflect only the start-cycle value.

Reset release also coincides with the first start bit. This is provoked both at power-up and after an abort in mid-frame, and it is judged by requiring the low line and the pulse in that very cycle. The frame timing is judged against a count kept by the bench.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   // What the line carries at the current bit position
   typedef enum logic [2:0] {
      FLD_START  = 3'd0,
      FLD_DATA   = 3'd1,
      FLD_PARITY = 3'd2,
      FLD_STOP   = 3'd3,
      FLD_IDLE   = 3'd4
   } field_t;

   // Bits per frame: start, data, parity, stop, then an equal-length idle run
   function automatic int unsigned frame_bits(input int unsigned channels);
      return 2 * (channels + 3);
   endfunction

   function automatic int unsigned safe_clog2(input int unsigned v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/bfs_bit_timer.sv
module bfs_bit_timer #(
   parameter int unsigned CLKS_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst,
   output logic bit_first,
   output logic bit_last
);
   import bfs_pkg::*;

   localparam int unsigned CW = safe_clog2(CLKS_PER_BIT);
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
   localparam bit POW2 = ((CLKS_PER_BIT & (CLKS_PER_BIT - 1)) == 0);

   initial begin
      assert (CLKS_PER_BIT >= 2)
         else $error("bfs_bit_timer: CLKS_PER_BIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         // Power-of-two period: the counter wraps on its own
         always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         // Other periods: explicit compare and clear
         always_ff @(posedge clk) begin
            if (rst)              cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign bit_first = (cnt == '0);
   assign bit_last  = (cnt == LAST);

endmodule

// File: rtl/bfs_frame_seq.sv
module bfs_frame_seq #(
   parameter int unsigned CHANNELS = 32
) (
   input  logic                                        clk,
   input  logic                                        rst,
   input  logic                                        bit_last,
   output bfs_pkg::field_t                             field,
   output logic [bfs_pkg::safe_clog2(CHANNELS)-1:0]    data_sel,
   output logic                                        at_start
);
   import bfs_pkg::*;

   localparam int unsigned FBITS = frame_bits(CHANNELS);
   localparam int unsigned IW    = safe_clog2(FBITS);
   localparam int unsigned SW    = safe_clog2(CHANNELS);

   localparam logic [IW-1:0] POS_LAST_DATA = IW'(CHANNELS);
   localparam logic [IW-1:0] POS_PARITY    = IW'(CHANNELS + 1);
   localparam logic [IW-1:0] POS_STOP      = IW'(CHANNELS + 2);
   localparam logic [IW-1:0] POS_END       = IW'(FBITS - 1);

   initial begin
      assert (CHANNELS >= 1)
         else $error("bfs_frame_seq: CHANNELS must be at least 1");
   end

   logic [IW-1:0] pos;
   logic [IW-1:0] pos_m1;

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (bit_last)
         pos <= (pos == POS_END) ? '0 : pos + 1'b1;
   end

   assign pos_m1   = pos - 1'b1;
   assign data_sel = SW'(pos_m1);
   assign at_start = (pos == '0);

   always_comb begin
      if (pos == '0)                field = FLD_START;
      else if (pos <= POS_LAST_DATA) field = FLD_DATA;
      else if (pos == POS_PARITY)    field = FLD_PARITY;
      else if (pos == POS_STOP)      field = FLD_STOP;
      else                           field = FLD_IDLE;
   end

endmodule

// File: rtl/bfs_word_hold.sv
module bfs_word_hold #(
   parameter int unsigned CHANNELS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [CHANNELS-1:0] din,
   output logic [CHANNELS-1:0] word,
   output logic                parity
);

   always_ff @(posedge clk) begin
      if (rst)       word <= '0;
      else if (load) word <= din;
   end

   // Even parity: the XOR of the held channels makes the total ones count even
   assign parity = ^word;

endmodule

// File: rtl/bkp_frame_tx.sv
module bkp_frame_tx #(
   parameter int unsigned CHANNELS     = 32,
   parameter int unsigned CLKS_PER_BIT = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CHANNELS-1:0] par_in,
   output logic                ser_out,
   output logic                frame_start
);
   import bfs_pkg::*;

   localparam int unsigned SW = safe_clog2(CHANNELS);

   initial begin
      assert (CHANNELS >= 1 && CLKS_PER_BIT >= 2)
         else $error("bkp_frame_tx: illegal parameter set");
   end

   logic          bit_first;
   logic          bit_last;
   field_t        field;
   logic [SW-1:0] data_sel;
   logic          at_start;
   logic [CHANNELS-1:0] held_word;
   logic          held_parity;
   logic          line_bit;

   bfs_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .bit_first (bit_first),
      .bit_last  (bit_last)
   );

   bfs_frame_seq #(.CHANNELS(CHANNELS)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .bit_last (bit_last),
      .field    (field),
      .data_sel (data_sel),
      .at_start (at_start)
   );

   assign frame_start = !rst && at_start && bit_first;

   bfs_word_hold #(.CHANNELS(CHANNELS)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .load   (frame_start),
      .din    (par_in),
      .word   (held_word),
      .parity (held_parity)
   );

   always_comb begin
      unique case (field)
         FLD_START:  line_bit = 1'b0;
         FLD_DATA:   line_bit = held_word[data_sel];
         FLD_PARITY: line_bit = held_parity;
         default:    line_bit = 1'b1;
      endcase
   end

   assign ser_out = rst ? 1'b1 : line_bit;

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
   parameter int unsigned CHANNELS     = 32,
   parameter int unsigned CLKS_PER_BIT = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                ser_out,
   input logic                frame_start,
   input logic [CHANNELS-1:0] held_word
);
   localparam int unsigned FCLKS      = 2 * (CHANNELS + 3) * CLKS_PER_BIT;
   localparam int unsigned CW         = $clog2(FCLKS);
   localparam int unsigned STOP_FIRST = (CHANNELS + 2) * CLKS_PER_BIT;

   logic [CW-1:0] cyc;

   always_ff @(posedge clk) begin
      if (rst)                             cyc <= '0;
      else if (cyc == CW'(FCLKS - 1))      cyc <= '0;
      else                                 cyc <= cyc + 1'b1;
   end

   assert_idle_in_reset_R1: assert property (@(posedge clk)
      rst |-> (ser_out && !frame_start));

   assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
      (cyc < CW'(CLKS_PER_BIT)) |-> !ser_out);

   assert_stop_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
      (cyc >= CW'(STOP_FIRST)) |-> ser_out);

   assert_pulse_period_R7: assert property (@(posedge clk) disable iff (rst)
      frame_start == (cyc == '0));

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);

   assert_word_held_R8: assert property (@(posedge clk) disable iff (rst)
      !frame_start |=> $stable(held_word));

endmodule

bind bkp_frame_tx bfs_checker #(
   .CHANNELS     (CHANNELS),
   .CLKS_PER_BIT (CLKS_PER_BIT)
) u_bfs_checker (
   .clk         (clk),
   .rst         (rst),
   .ser_out     (ser_out),
   .frame_start (frame_start),
   .held_word   (held_word)
);

// File: tb/test_bkp_frame_tx.sv
`timescale 1ns/1ps
module test_bkp_frame_tx;
   localparam int N     = 4;
   localparam int CPB   = 8;
   localparam int FBITS = 2 * (N + 3);
   localparam int FCLK  = FBITS * CPB;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] par_in = '0;
   logic         ser_out;
   logic         frame_start;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bkp_frame_tx #(.CHANNELS(N), .CLKS_PER_BIT(CPB)) i_bkp_frame_tx (
      .clk         (clk),
      .rst         (rst),
      .par_in      (par_in),
      .ser_out     (ser_out),
      .frame_start (frame_start)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] pattern(input int idx);
      if (idx < (1 << N)) return N'(idx);
      return N'(idx * 37 + 5);
   endfunction

   function automatic logic exp_line(input logic [N-1:0] w, input int pos);
      if (pos == 0) return 1'b0;
      if (pos <= N) return w[pos-1];
      if (pos == N + 1) return ^w;
      return 1'b1;
   endfunction

   // Called at the negedge of the first cycle after reset release.
   // k counts cycles since release. The bit position is k/CPB, which fixes
   // the bit length (R3).
   task automatic run(input int ncyc, input int pat_base);
      logic [N-1:0] w = '0;
      for (int k = 0; k < ncyc; k++) begin
         int kp  = k % FCLK;
         int pos = kp / CPB;
         if (kp == 0) begin
            w = pattern(pat_base + k / FCLK);
            par_in = w;           // present during the capture cycle (R8)
         end else if (kp == 1) begin
            par_in = ~w;          // later change must not be sent (R8)
         end
         #1;
         if (pos == 0)
            chk(k == 0 ? "R2 start bit" : "R4 start bit", ser_out, 1'b0);
         else if (pos <= N)
            chk("R3 R4 R8 data bit", ser_out, exp_line(w, pos));
         else if (pos == N + 1)
            chk("R5 R8 parity bit", ser_out, exp_line(w, pos));
         else
            chk("R6 stop/idle bit", ser_out, 1'b1);
         chk(k == 0 ? "R2 frame_start" : "R7 frame_start", frame_start, kp == 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (4) begin
         @(negedge clk);
         #1;
         chk("R1 ser_out in reset", ser_out, 1'b1);
         chk("R1 frame_start in reset", frame_start, 1'b0);
      end
      @(negedge clk);
      rst = 1'b0;
      // exhaustive sweep of all 16 words, then extra patterns
      run(FCLK * ((1 << N) + 2) + 300, 0);
      // R9: abort mid-frame
      rst = 1'b1;
      repeat (5) begin
         #1;
         chk("R9 R1 ser_out during abort", ser_out, 1'b1);
         chk("R9 R1 frame_start during abort", frame_start, 1'b0);
         @(negedge clk);
      end
      rst = 1'b0;
      run(FCLK * 3, 9);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule